// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This unit performs the compare half and the branch half of a compare-then-jump sequence. A compare request subtracts the second operand from the first. It discards the difference and keeps only five status flags, which it holds in a register until the next compare. The second operand is either a full register value or a short immediate, and the immediate is sign-extended first. The subtraction runs at a 16-bit or 32-bit operand size.

A branch request resolves a conditional relative jump. It takes a 4-bit condition code that is tested against the held flags, or a count-zero test that ignores the flags and looks at the count register. A taken branch adds a signed 8-bit or 32-bit displacement to the address of the following instruction. A branch that is not taken falls through to that address. With a 16-bit operand size, the upper half of the resulting pointer is cleared. All outputs are registered, one cycle after the request.

Top module: `cmp_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `flags_o`, `br_done`, `taken` and `next_ip` are all zero.
- R2: A cycle with `cmp_valid` high loads `flags_o` at the next edge with the flags of `op_a - op_b`. `flags_o` bit positions are: [0] carry, [1] parity, [2] zero, [3] sign, [4] overflow. Without `cmp_valid`, `flags_o` keeps its value, and branch requests do not change it.
- R3: When `use_imm` is 1, the second operand is `imm` sign-extended to the operand width, in place of `op_b`.
- R4: With `size32`=1 the subtraction uses all 32 bits. With `size32`=0 it uses bits [15:0] of both operands, and the flags refer to a 16-bit result.
- R5: Carry is set on unsigned borrow. Sign is the result's top bit, and zero is set when the result is zero. Overflow is set when the operand signs differ and the result's sign differs from the first operand's.
- R6: Parity is set when the low byte of the result holds an even number of one bits.
- R7: Condition codes for even values are: 0 overflow, 2 carry, 4 zero, 6 carry or zero, 8 sign, 10 parity, 12 sign≠overflow, 14 zero or sign≠overflow. Each odd code is the negation of the even code below it. Code 7 is therefore "above" (carry=0 and zero=0).
- R8: The signed codes (12–15) and the unsigned codes (2, 3, 6, 7) can disagree on the same compare. For example, -1 against 1 is "above" and "less" at once.
- R9: A cycle with `br_valid` high gives, one cycle later, `br_done`=1 and `taken` set to the condition outcome. `next_ip` is `ip_seq` plus the sign-extended displacement when taken, otherwise `ip_seq`. The displacement is `disp[7:0]` sign-extended when `disp_short`=1, otherwise all of `disp`. Without `br_valid`, `br_done` and `taken` are 0 in the next cycle.
- R10: For a branch with `size32`=0, bits [31:16] of `next_ip` are zero, whether the branch is taken or not.
- R11: With `count_jmp`=1, `cond` and the flags are ignored and the branch is taken exactly when the count is zero. The count tested is `count[15:0]` when `addr32`=0 and all of `count` when `addr32`=1.
- R12: A branch in the same cycle as a compare is resolved against the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare request |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register form) |
| imm | input | 8 | Short immediate second operand |
| use_imm | input | 1 | 1 selects the sign-extended immediate |
| size32 | input | 1 | Operand size: 1 = 32-bit, 0 = 16-bit |
| br_valid | input | 1 | Branch request |
| cond | input | 4 | Condition code |
| count_jmp | input | 1 | 1 = count-zero jump |
| addr32 | input | 1 | Address size for the count test: 1 = 32-bit, 0 = 16-bit |
| ip_seq | input | 32 | Address of the following instruction |
| count | input | 32 | Count register |
| disp | input | 32 | Signed displacement |
| disp_short | input | 1 | 1 = use `disp[7:0]` sign-extended |
| flags_o | output | 5 | Held status flags |
| br_done | output | 1 | Branch result valid |
| taken | output | 1 | Branch taken |
| next_ip | output | 32 | Resolved instruction pointer |

## Verification
The bench runs the five flag boundaries: equal operands, a borrow, signed overflow at the positive limit, a 16-bit compare whose upper halves differ, and an all-ones immediate. A design that zero-extends the immediate, or that looks at 32 bits for a 16-bit compare, shows the wrong carry or zero flag. After compares whose signed and unsigned orders disagree, every condition code is swept, which exposes an inverted pair or a mixed-up signed and unsigned code. Further checks aim at a pointer that wraps past 16 bits, a negative short displacement, a count whose low half alone is zero, and a branch issued in the same cycle as a compare. A wrong design there leaks upper pointer bits, takes the count jump at the wrong address size, or reads the new flags too early.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int FLAG_N = 5;

  // bit 0 carry, 1 parity, 2 zero, 3 sign, 4 overflow
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } flags_t;

  typedef enum logic [2:0] {
    CP_OVF  = 3'd0,
    CP_CARRY = 3'd1,
    CP_ZERO = 3'd2,
    CP_BEQ  = 3'd3,
    CP_SIGN = 3'd4,
    CP_PAR  = 3'd5,
    CP_LT   = 3'd6,
    CP_LE   = 3'd7
  } cond_pair_e;
endpackage

// File: rtl/cbu_sub_flags.sv
module cbu_sub_flags
  import cbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output flags_t       f
);
  localparam int BYTE_W = 8;

  logic [W:0]   wide;
  logic [W-1:0] diff;

  always_comb begin
    wide = {1'b0, a} - {1'b0, b};
    diff = wide[W-1:0];
    f.cf = wide[W];
    f.sf = diff[W-1];
    f.zf = (diff == '0);
    f.pf = ~(^diff[BYTE_W-1:0]);
    f.of = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
  end

  // R5: an equal compare can neither borrow nor overflow
  always_comb begin
    a_r5_zero_no_borrow: assert (!(f.zf && (f.cf || f.of)));
  end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter int CC_W = 4
) (
  input  flags_t          f,
  input  logic [CC_W-1:0] cc,
  output logic            hold
);
  localparam int PAIR_W = CC_W - 1;

  logic       base;
  cond_pair_e pair;

  always_comb begin
    pair = cond_pair_e'(cc[CC_W-1:1]);
    unique case (pair)
      CP_OVF:   base = f.of;
      CP_CARRY: base = f.cf;
      CP_ZERO:  base = f.zf;
      CP_BEQ:   base = f.cf | f.zf;
      CP_SIGN:  base = f.sf;
      CP_PAR:   base = f.pf;
      CP_LT:    base = f.sf ^ f.of;
      CP_LE:    base = f.zf | (f.sf ^ f.of);
      default:  base = 1'b0;
    endcase
    hold = base ^ cc[0];
  end
endmodule

// File: rtl/cbu_target_gen.sv
module cbu_target_gen #(
  parameter int IP_W    = 32,
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [IP_W-1:0] ip_seq,
  input  logic [IP_W-1:0] disp,
  input  logic            disp_short,
  input  logic            take,
  input  logic            size32,
  output logic [IP_W-1:0] ip_out
);
  localparam int EXT_W = IP_W - SHORT_W;

  logic [IP_W-1:0] offs;
  logic [IP_W-1:0] sum;

  always_comb begin
    offs = disp_short ? {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]} : disp;
    sum  = take ? (ip_seq + offs) : ip_seq;
    ip_out = size32 ? sum : {{(IP_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int IMM_W  = 8,
  parameter int CC_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              size32,
  input  logic              br_valid,
  input  logic [CC_W-1:0]   cond,
  input  logic              count_jmp,
  input  logic              addr32,
  input  logic [DATA_W-1:0] ip_seq,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] disp,
  input  logic              disp_short,
  output logic [FLAG_N-1:0] flags_o,
  output logic              br_done,
  output logic              taken,
  output logic [DATA_W-1:0] next_ip
);
  localparam int N_SIZES = 2;
  localparam int EXT_W   = DATA_W - IMM_W;

  logic [DATA_W-1:0] b_sel;
  flags_t            size_flags [N_SIZES];
  flags_t            new_flags;
  flags_t            flags_q;
  logic              cc_hold;
  logic              cnt_zero;
  logic              take;
  logic [DATA_W-1:0] ip_calc;

  assign b_sel = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : op_b;

  // index 0: full width, index 1: half width
  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int W = (g == 0) ? DATA_W : HALF_W;
    cbu_sub_flags #(.W(W)) u_flags (
      .a (op_a[W-1:0]),
      .b (b_sel[W-1:0]),
      .f (size_flags[g])
    );
  end

  assign new_flags = size32 ? size_flags[0] : size_flags[1];

  cbu_cond_eval #(.CC_W(CC_W)) u_cond (
    .f    (flags_q),
    .cc   (cond),
    .hold (cc_hold)
  );

  assign cnt_zero = addr32 ? (count == '0) : (count[HALF_W-1:0] == '0);
  assign take     = count_jmp ? cnt_zero : cc_hold;

  cbu_target_gen #(.IP_W(DATA_W), .HALF_W(HALF_W), .SHORT_W(IMM_W)) u_tgt (
    .ip_seq     (ip_seq),
    .disp       (disp),
    .disp_short (disp_short),
    .take       (take),
    .size32     (size32),
    .ip_out     (ip_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      br_done <= 1'b0;
      taken   <= 1'b0;
      next_ip <= '0;
    end else begin
      if (cmp_valid) flags_q <= new_flags;
      br_done <= br_valid;
      taken   <= br_valid & take;
      if (br_valid) next_ip <= ip_calc;
    end
  end

  assign flags_o = flags_q;

  // R2: flags only move on a compare request
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(flags_o));

  // R9: a result appears exactly one cycle after each request
  a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> br_done);

  a_r9_no_stray_taken: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> (!br_done && !taken));

  // R10: 16-bit branches never leave upper pointer bits set
  a_r10_half_ip: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !size32) |=> (next_ip[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/sim_cmp_branch_unit.sv
module sim_cmp_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [7:0]  imm = '0;
  logic        use_imm = 1'b0, size32 = 1'b1;
  logic        br_valid = 1'b0;
  logic [3:0]  cond = '0;
  logic        count_jmp = 1'b0, addr32 = 1'b1;
  logic [31:0] ip_seq = '0, count = '0, disp = '0;
  logic        disp_short = 1'b0;
  logic [4:0]  flags_o;
  logic        br_done, taken;
  logic [31:0] next_ip;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [4:0] mflags = '0;

  always #5 clk = ~clk;

  cmp_branch_unit u0 (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .op_a(op_a), .op_b(op_b),
    .imm(imm), .use_imm(use_imm), .size32(size32), .br_valid(br_valid),
    .cond(cond), .count_jmp(count_jmp), .addr32(addr32), .ip_seq(ip_seq),
    .count(count), .disp(disp), .disp_short(disp_short), .flags_o(flags_o),
    .br_done(br_done), .taken(taken), .next_ip(next_ip)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] model_flags(logic [31:0] a, logic [31:0] b,
                                             logic [7:0] im, logic ui, logic s32);
    logic [31:0] bb, mask, d;
    logic [32:0] w;
    int top;
    logic cf, pf, zf, sf, of;
    bb   = ui ? {{24{im[7]}}, im} : b;
    mask = s32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    top  = s32 ? 31 : 15;
    w    = {1'b0, a & mask} - {1'b0, bb & mask};
    d    = w[31:0] & mask;
    cf   = s32 ? w[32] : ((a & mask) < (bb & mask));
    zf   = (d == 0);
    sf   = d[top];
    pf   = ($countones(d[7:0]) % 2) == 0;
    of   = (a[top] != bb[top]) && (d[top] != a[top]);
    return {of, sf, zf, pf, cf};
  endfunction

  function automatic logic model_cond(logic [3:0] cc, logic [4:0] f);
    logic r;
    case (cc[3:1])
      3'd0: r = f[4];
      3'd1: r = f[0];
      3'd2: r = f[2];
      3'd3: r = f[0] | f[2];
      3'd4: r = f[3];
      3'd5: r = f[1];
      3'd6: r = f[3] ^ f[4];
      default: r = f[2] | (f[3] ^ f[4]);
    endcase
    return cc[0] ? ~r : r;
  endfunction

  task automatic do_cmp(string req, logic [31:0] a, logic [31:0] b,
                        logic [7:0] im, logic ui, logic s32);
    @(negedge clk);
    op_a = a; op_b = b; imm = im; use_imm = ui; size32 = s32; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    mflags = model_flags(a, b, im, ui, s32);
    check(req, {27'd0, flags_o}, {27'd0, mflags});
  endtask

  task automatic do_br(string req, logic [3:0] cc, logic cz, logic a32, logic s32,
                       logic [31:0] seq, logic [31:0] cnt, logic [31:0] dsp, logic ds);
    logic t;
    logic [31:0] off, ip;
    @(negedge clk);
    cond = cc; count_jmp = cz; addr32 = a32; size32 = s32; ip_seq = seq;
    count = cnt; disp = dsp; disp_short = ds; br_valid = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
    if (cz) t = a32 ? (cnt == 0) : (cnt[15:0] == 0);
    else    t = model_cond(cc, mflags);
    off = ds ? {{24{dsp[7]}}, dsp[7:0]} : dsp;
    ip  = t ? seq + off : seq;
    if (!s32) ip[31:16] = 16'h0;
    check({req, " done"}, {31'd0, br_done}, 32'd1);
    check({req, " taken"}, {31'd0, taken}, {31'd0, t});
    check({req, " ip"}, next_ip, ip);
    check({req, " flags kept (R2)"}, {27'd0, flags_o}, {27'd0, mflags});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 flags", {27'd0, flags_o}, 32'd0);
    check("R1 done", {31'd0, br_done}, 32'd0);
    check("R1 taken", {31'd0, taken}, 32'd0);
    check("R1 ip", next_ip, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_flags();
    do_cmp("R2 R5 equal", 32'h1234_5678, 32'h1234_5678, 8'h0, 1'b0, 1'b1);
    check("R5 zf set", {31'd0, flags_o[2]}, 32'd1);
    do_cmp("R5 borrow", 32'd3, 32'd5, 8'h0, 1'b0, 1'b1);
    check("R5 cf set", {31'd0, flags_o[0]}, 32'd1);
    do_cmp("R5 overflow", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 8'h0, 1'b0, 1'b1);
    check("R5 of set", {31'd0, flags_o[4]}, 32'd1);
    do_cmp("R6 parity", 32'h0000_0010, 32'h0000_000D, 8'h0, 1'b0, 1'b1);
    check("R6 pf for 0x03", {31'd0, flags_o[1]}, 32'd1);
    do_cmp("R4 half equal", 32'h1234_0001, 32'h5678_0001, 8'h0, 1'b0, 1'b0);
    check("R4 zf on low half", {31'd0, flags_o[2]}, 32'd1);
    do_cmp("R4 half overflow", 32'h0000_8000, 32'h0000_0001, 8'h0, 1'b0, 1'b0);
  endtask

  task automatic t_imm();
    do_cmp("R3 imm -1", 32'd0, 32'd0, 8'hFF, 1'b1, 1'b1);
    check("R3 cf with extended imm", {31'd0, flags_o[0]}, 32'd1);
    do_cmp("R3 imm half", 32'h0000_FF80, 32'h0000_0001, 8'h80, 1'b1, 1'b0);
    check("R3 zf half imm", {31'd0, flags_o[2]}, 32'd1);
  endtask

  task automatic t_cond_sweep();
    do_cmp("R8 setup -1 vs 1", 32'hFFFF_FFFF, 32'd1, 8'h0, 1'b0, 1'b1);
    for (int c = 0; c < 16; c++)
      do_br("R7 R8 sweep A", 4'(c), 1'b0, 1'b1, 1'b1, 32'h100, 32'd1, 32'h40, 1'b0);
    do_cmp("R8 setup 3 vs 5", 32'd3, 32'd5, 8'h0, 1'b0, 1'b1);
    for (int c = 0; c < 16; c++)
      do_br("R7 R8 sweep B", 4'(c), 1'b0, 1'b1, 1'b1, 32'h200, 32'd1, 32'h10, 1'b0);
    do_cmp("R7 setup equal", 32'd9, 32'd9, 8'h0, 1'b0, 1'b1);
    for (int c = 0; c < 16; c++)
      do_br("R7 sweep C", 4'(c), 1'b0, 1'b1, 1'b1, 32'h300, 32'd1, 32'h8, 1'b1);
  endtask

  task automatic t_target();
    do_cmp("R9 setup", 32'd1, 32'd1, 8'h0, 1'b0, 1'b1);
    do_br("R9 short negative", 4'd4, 1'b0, 1'b1, 1'b1, 32'h1000, 32'd1, 32'h0000_00F0, 1'b1);
    check("R9 ip value", next_ip, 32'h0000_0FF0);
    do_br("R9 long", 4'd4, 1'b0, 1'b1, 1'b1, 32'h1000, 32'd1, 32'h0010_0000, 1'b0);
    do_br("R9 not taken", 4'd5, 1'b0, 1'b1, 1'b1, 32'h1000, 32'd1, 32'h0010_0000, 1'b0);
    do_br("R10 wrap", 4'd4, 1'b0, 1'b1, 1'b0, 32'h0000_FFF0, 32'd1, 32'h20, 1'b1);
    check("R10 ip truncated", next_ip, 32'h0000_0010);
    do_br("R10 fallthrough", 4'd5, 1'b0, 1'b1, 1'b0, 32'h0001_2345, 32'd1, 32'h20, 1'b1);
    @(negedge clk);
    check("R9 done drops", {31'd0, br_done}, 32'd0);
    check("R9 taken drops", {31'd0, taken}, 32'd0);
  endtask

  task automatic t_count();
    do_cmp("R11 setup", 32'd1, 32'd1, 8'h0, 1'b0, 1'b1);
    do_br("R11 cx zero", 4'd5, 1'b1, 1'b0, 1'b1, 32'h500, 32'h0001_0000, 32'h4, 1'b1);
    check("R11 16-bit count taken", {31'd0, taken}, 32'd1);
    do_br("R11 ecx nonzero", 4'd4, 1'b1, 1'b1, 1'b1, 32'h500, 32'h0001_0000, 32'h4, 1'b1);
    check("R11 32-bit count not taken", {31'd0, taken}, 32'd0);
    do_br("R11 ecx zero", 4'd5, 1'b1, 1'b1, 1'b1, 32'h500, 32'h0, 32'h4, 1'b1);
  endtask

  task automatic t_same_cycle();
    logic [4:0] old_f;
    do_cmp("R12 setup", 32'd7, 32'd7, 8'h0, 1'b0, 1'b1);
    old_f = mflags;
    @(negedge clk);
    op_a = 32'd1; op_b = 32'd2; use_imm = 1'b0; size32 = 1'b1; cmp_valid = 1'b1;
    cond = 4'd4; count_jmp = 1'b0; ip_seq = 32'h800; disp = 32'h10; disp_short = 1'b1;
    br_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0; br_valid = 1'b0;
    check("R12 uses old zero flag", {31'd0, taken}, {31'd0, model_cond(4'd4, old_f)});
    check("R12 ip", next_ip, 32'h810);
    mflags = model_flags(32'd1, 32'd2, 8'h0, 1'b0, 1'b1);
    check("R12 flags updated", {27'd0, flags_o}, {27'd0, mflags});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flags();
    t_imm();
    t_cond_sweep();
    t_target();
    t_count();
    t_same_cycle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule